// File: doc/BRIEF.md
# Event-Driven PWM Generator with Glitch-Free Duty Extremes

This block makes one pulse-width-modulated output from a free-running counter. A programmable divider slows the counter. The output never follows a comparison directly. A set event or a clear event moves it, and each event fires when the counter reaches a value taken from the programmed width. Two counting shapes are available. The sawtooth shape counts up and wraps, which gives an edge-aligned pulse. The triangle shape counts up and then back down, which gives a pulse centred in the period.

The event conditions are arranged so that a width of zero never produces a set event one tick before a clear event. The output therefore stays flat at zero duty and at full duty, in both shapes. Software writes the period and the width into holding copies. These copies move into the working registers only when the counter returns to zero, so a running waveform never shows a partial period. While the block is stopped, the output rests at a programmable idle level.

Top module: `pwm_evt_gen`

## Requirements
- R1: Register 3 is the control word. Bit 0 runs the block, bit 1 selects the triangle shape and bit 2 is the idle level. While bit 0 is clear, the counter rests at zero and the output is driven to the idle level one clock after each edge. After reset the output is 0.
- R2: Register 2 holds the divider value D. While running, the counter steps once every D+1 clocks. The first step comes D+1 clocks after the edge that starts the block.
- R3: Register 0 holds the period P and register 1 holds the width W. In sawtooth shape the counter visits 0 to P-1 and wraps. For 1 ≤ W < P, the output is high for the first W ticks of each period and low for the rest.
- R4: In sawtooth shape with W = 0, the output stays low for the whole run with no one-tick pulse. When a set event and a clear event fall on the same tick, the clear event wins.
- R5: In sawtooth shape, W = P holds the output high. Any W > P (for example P+2) suppresses the set event and holds the output low.
- R6: In triangle shape the counter goes 0 up to P and back down to 1, so one period is 2P ticks. For 1 ≤ W < P, the output is high for 2W ticks centred on the peak: set on the way up at count P-W, cleared on the way down at count P-W.
- R7: In triangle shape, W = 0 holds the output low. W ≥ P (including P+2) holds it high.
- R8: While running, writes to the period or width registers take effect only at the start of the next period. A write that lands on the same clock edge as the period boundary takes effect in the period that begins at that boundary.
- R9: The output is registered. While running, it changes only on a clock edge where the counter steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 width, 2 divider, 3 control |
| wr_data | input | DATA_W | Write data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Two things can land on one clock edge: a software write of the width, and the period-boundary transfer of the holding copies into the working registers. The bench places a width write exactly on the wrap edge, one edge later, and in the middle of a period. It expects the new width to appear from the next period in the first and third cases, and one period later in the second. A scoreboard compares the output against a per-clock expectation derived from the duty formulas. A checker confirms that no working register moves between boundaries, and that a coincident set and clear always leaves the output low.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

   typedef enum logic [1:0] {
      SEL_PERIOD = 2'd0,
      SEL_WIDTH  = 2'd1,
      SEL_DIV    = 2'd2,
      SEL_CTRL   = 2'd3
   } reg_sel_e;

   // bit 0 run, bit 1 triangle shape, bit 2 idle level
   typedef struct packed {
      logic idle_lvl;
      logic tri_mode;
      logic run;
   } ctrl_t;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;

   localparam int CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
   import pwm_evt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              boundary,
   output logic [CNT_W-1:0]  act_period,
   output logic [CNT_W-1:0]  act_width,
   output logic [DIV_W-1:0]  div_val,
   output ctrl_t             ctrl
);

   logic [CNT_W-1:0] hold_period, hold_width;
   logic             wr_per, wr_wid, wr_div, wr_ctl;
   logic             upd;

   assign wr_per = wr_en && (reg_sel_e'(wr_addr) == SEL_PERIOD);
   assign wr_wid = wr_en && (reg_sel_e'(wr_addr) == SEL_WIDTH);
   assign wr_div = wr_en && (reg_sel_e'(wr_addr) == SEL_DIV);
   assign wr_ctl = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);

   // working copies follow the holding copies while stopped or at a wrap
   assign upd = boundary || !ctrl.run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_period <= CNT_W'(2);
         hold_width  <= '0;
         act_period  <= CNT_W'(2);
         act_width   <= '0;
         div_val     <= '0;
         ctrl        <= '0;
      end else begin
         if (wr_per) hold_period <= wr_data[CNT_W-1:0];
         if (wr_wid) hold_width  <= wr_data[CNT_W-1:0];
         if (wr_div) div_val     <= wr_data[DIV_W-1:0];
         if (wr_ctl) ctrl        <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
         if (upd) begin
            act_period <= wr_per ? wr_data[CNT_W-1:0] : hold_period;
            act_width  <= wr_wid ? wr_data[CNT_W-1:0] : hold_width;
         end
      end
   end

endmodule

// File: rtl/pwm_evt_divider.sv
module pwm_evt_divider #(
   parameter int DIV_W   = 8,
   parameter bit USE_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);

   generate
      if (USE_DIV) begin : g_div
         logic [DIV_W-1:0] pre_q;
         logic             hit;

         assign hit  = (pre_q >= div_val);
         assign tick = run && hit;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre_q <= '0;
            else if (!run)    pre_q <= '0;
            else if (hit)     pre_q <= '0;
            else              pre_q <= pre_q + 1'b1;
         end
      end else begin : g_nodiv
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ (^div_val);
         assign tick      = run;
      end
   endgenerate

endmodule

// File: rtl/pwm_evt_counter.sv
module pwm_evt_counter
   import pwm_evt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tri_mode,
   input  logic             tick,
   input  logic [CNT_W-1:0] per_eff,
   output logic [CNT_W-1:0] cnt,
   output cnt_dir_e         dir,
   output logic             wrap
);

   logic [CNT_W-1:0] per_m1;
   logic             saw_last, tri_last, tri_peak;

   assign per_m1   = per_eff - 1'b1;
   assign saw_last = (cnt >= per_m1);
   assign tri_peak = (dir == DIR_UP) && (cnt >= per_m1);
   assign tri_last = (dir == DIR_DOWN) && (cnt <= CNT_W'(1));
   assign wrap     = tick && (tri_mode ? tri_last : saw_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         dir <= DIR_UP;
      end else if (!run) begin
         cnt <= '0;
         dir <= DIR_UP;
      end else if (tick) begin
         if (!tri_mode) begin
            dir <= DIR_UP;
            cnt <= saw_last ? '0 : cnt + 1'b1;
         end else if (tri_last) begin
            cnt <= '0;
            dir <= DIR_UP;
         end else if (tri_peak) begin
            cnt <= cnt + 1'b1;
            dir <= DIR_DOWN;
         end else if (dir == DIR_UP) begin
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwm_evt_match.sv
module pwm_evt_match
   import pwm_evt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             tri_mode,
   input  logic [CNT_W-1:0] per_eff,
   input  logic [CNT_W-1:0] width,
   input  logic [CNT_W-1:0] cnt,
   input  cnt_dir_e         dir,
   output logic             set_ev,
   output logic             clr_ev
);

   logic             at_zero, w_zero, w_over, w_full;
   logic [CNT_W-1:0] mid_cmp;

   assign at_zero = (cnt == '0);
   assign w_zero  = (width == '0);
   assign w_over  = (width > per_eff);
   assign w_full  = (width >= per_eff);
   assign mid_cmp = per_eff - width;

   always_comb begin
      set_ev = 1'b0;
      clr_ev = 1'b0;
      if (!tri_mode) begin
         // unreachable widths lose their set event and clear at the wrap
         set_ev = at_zero && !w_zero && !w_over;
         clr_ev = (cnt == width) || (at_zero && w_over);
      end else if (w_full) begin
         set_ev = (dir == DIR_UP) && at_zero;
      end else begin
         set_ev = (dir == DIR_UP)   && (cnt == mid_cmp);
         clr_ev = (dir == DIR_DOWN) && (cnt == mid_cmp);
      end
   end

endmodule

// File: rtl/pwm_evt_outreg.sv
module pwm_evt_outreg (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic idle_lvl,
   input  logic tick,
   input  logic set_ev,
   input  logic clr_ev,
   output logic pwm_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pwm_out <= 1'b0;
      else if (!run)           pwm_out <= idle_lvl;
      else if (tick && clr_ev) pwm_out <= 1'b0;
      else if (tick && set_ev) pwm_out <= 1'b1;
   end

endmodule

// File: rtl/pwm_evt_gen.sv
module pwm_evt_gen
   import pwm_evt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DIV_W   = 8,
   parameter int DATA_W  = 16,
   parameter bit USE_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_out
);

   generate
      if (CNT_W < 2)         begin : g_bad_cnt  $error("CNT_W must be at least 2");        end
      if (DIV_W < 1)         begin : g_bad_div  $error("DIV_W must be at least 1");        end
      if (DATA_W < CNT_W)    begin : g_bad_dw   $error("DATA_W must cover CNT_W");         end
      if (DATA_W < DIV_W)    begin : g_bad_dw2  $error("DATA_W must cover DIV_W");         end
      if (DATA_W < CTRL_BITS) begin : g_bad_dw3 $error("DATA_W must cover control bits");  end
   endgenerate

   logic [CNT_W-1:0] act_period, act_width, per_eff, cnt;
   logic [DIV_W-1:0] div_val;
   ctrl_t            ctrl;
   cnt_dir_e         dir;
   logic             tick, wrap, set_ev, clr_ev;
   logic             run_w, tri_w, idle_w;

   assign run_w   = ctrl.run;
   assign tri_w   = ctrl.tri_mode;
   assign idle_w  = ctrl.idle_lvl;
   assign per_eff = (act_period == '0) ? CNT_W'(1) : act_period;

   pwm_evt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .boundary(wrap), .act_period(act_period), .act_width(act_width),
      .div_val(div_val), .ctrl(ctrl)
   );

   pwm_evt_divider #(.DIV_W(DIV_W), .USE_DIV(USE_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run_w), .div_val(div_val), .tick(tick)
   );

   pwm_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_w), .tri_mode(tri_w), .tick(tick),
      .per_eff(per_eff), .cnt(cnt), .dir(dir), .wrap(wrap)
   );

   pwm_evt_match #(.CNT_W(CNT_W)) u_match (
      .tri_mode(tri_w), .per_eff(per_eff), .width(act_width), .cnt(cnt), .dir(dir),
      .set_ev(set_ev), .clr_ev(clr_ev)
   );

   pwm_evt_outreg u_out (
      .clk(clk), .rst_n(rst_n), .run(run_w), .idle_lvl(idle_w), .tick(tick),
      .set_ev(set_ev), .clr_ev(clr_ev), .pwm_out(pwm_out)
   );

endmodule

// File: rtl/pwm_evt_checker.sv
module pwm_evt_checker #(
   parameter int CNT_W = 16,
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tri_mode,
   input logic             idle_lvl,
   input logic             tick,
   input logic             wrap,
   input logic             set_ev,
   input logic             clr_ev,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] per_eff,
   input logic [CNT_W-1:0] act_period,
   input logic [CNT_W-1:0] act_width,
   input logic [DIV_W-1:0] div_val,
   input logic             pwm_out
);

   assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pwm_out == $past(idle_lvl)));

   assert_divider_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_val != '0) |=> (!tick || div_val == '0));

   assert_saw_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tri_mode && $past(run) && !$past(tri_mode)) |-> (cnt < per_eff));

   assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && set_ev && !clr_ev) |=> pwm_out);

   assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && clr_ev) |=> !pwm_out);

   assert_tri_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tri_mode) |-> (cnt <= per_eff));

   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> ($stable(act_width) && $stable(act_period)));

   assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(pwm_out));

endmodule

bind pwm_evt_gen pwm_evt_checker #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_w), .tri_mode(tri_w), .idle_lvl(idle_w),
   .tick(tick), .wrap(wrap), .set_ev(set_ev), .clr_ev(clr_ev), .cnt(cnt),
   .per_eff(per_eff), .act_period(act_period), .act_width(act_width),
   .div_val(div_val), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_evt_gen.sv
`timescale 1ns/1ps
module tb_pwm_evt_gen;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          pwm_out;

   int total = 0;
   int bad   = 0;
   bit armed = 1'b0;

   typedef struct {
      logic  lvl;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   pwm_evt_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_out(pwm_out)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: pwm_out=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: one expected level per clock while armed
   always @(posedge clk) begin
      #1;
      if (armed && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(pwm_out, e.lvl, e.tag);
      end
   end

   task automatic reg_wr(input logic [1:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // level after tick m, straight from the duty rules R3..R7
   function automatic logic lvl_at(input bit tri_m, input int p, input int w, input int m);
      int len, ph;
      len = tri_m ? 2 * p : p;
      ph  = m % len;
      if (!tri_m) begin
         if (w == 0 || w > p) return 1'b0;
         if (w == p) return 1'b1;
         return (ph < w);
      end
      if (w >= p) return 1'b1;
      if (w == 0) return 1'b0;
      return (ph >= p - w) && (ph < p + w);
   endfunction

   task automatic run_case(input bit tri_m, input bit idle, input int p, input int w0,
                           input int w1, input int sw_per, input int d, input int nclk,
                           input int wr_at, input string tag);
      int ctl;
      ctl = (int'(idle) << 2) | (int'(tri_m) << 1);
      reg_wr(2'd0, p);
      reg_wr(2'd1, w0);
      reg_wr(2'd2, d);
      reg_wr(2'd3, ctl);
      // driver: push the expected level for every clock after the start edge
      for (int i = 0; i < nclk; i++) begin
         exp_t e;
         int n, m, len, w;
         n = i / (d + 1);
         e.tag = tag;
         if (n == 0) e.lvl = idle;
         else begin
            m   = n - 1;
            len = tri_m ? 2 * p : p;
            w   = (m / len >= sw_per) ? w1 : w0;
            e.lvl = lvl_at(tri_m, p, w, m);
         end
         sb.push_back(e);
      end
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = DW'(ctl | 1);
      armed = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      if (wr_at > 0) begin
         repeat (wr_at - 1) @(negedge clk);
         wr_en = 1'b1; wr_addr = 2'd1; wr_data = DW'(w1);
         @(negedge clk);
         wr_en = 1'b0;
      end
      wait (sb.size() == 0);
      @(negedge clk);
      armed = 1'b0;
      // stopping must return the output to the idle level (R1)
      reg_wr(2'd3, ctl);
      @(posedge clk); #1;
      chk(pwm_out, idle, "R1 idle after stop");
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(pwm_out, 1'b0, "R1 reset level");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(pwm_out, 1'b0, "R1 level after reset release");

      run_case(0, 0, 8, 3,  3,  1000, 0, 30, 0, "R3 saw W=3");
      run_case(0, 0, 5, 4,  4,  1000, 0, 16, 0, "R3 saw W=P-1");
      run_case(0, 0, 8, 0,  0,  1000, 0, 30, 0, "R4 saw zero width");
      run_case(0, 0, 8, 8,  8,  1000, 0, 30, 0, "R5 saw full width");
      run_case(0, 0, 8, 10, 10, 1000, 0, 30, 0, "R5 saw width P+2 low");
      run_case(1, 0, 5, 2,  2,  1000, 0, 35, 0, "R6 tri W=2");
      run_case(1, 0, 5, 1,  1,  1000, 0, 25, 0, "R6 tri W=1");
      run_case(1, 0, 5, 0,  0,  1000, 0, 25, 0, "R7 tri zero width");
      run_case(1, 0, 5, 5,  5,  1000, 0, 25, 0, "R7 tri width P");
      run_case(1, 0, 5, 7,  7,  1000, 0, 25, 0, "R7 tri width P+2");
      run_case(0, 0, 4, 1,  1,  1000, 2, 40, 0, "R2 R9 divide by 3");
      run_case(0, 1, 8, 3,  3,  1000, 3, 50, 0, "R1 R2 idle high then run");
      run_case(0, 0, 6, 2,  4,  1,    0, 30, 3, "R8 write mid period");
      run_case(0, 0, 6, 2,  4,  1,    0, 30, 6, "R8 write on wrap edge");
      run_case(0, 0, 6, 2,  4,  2,    0, 30, 7, "R8 write after wrap edge");
      run_case(1, 0, 4, 1,  3,  1,    0, 30, 3, "R8 tri write mid period");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule